// File: doc/BRIEF.md
# Serial EEPROM Single-Word Read Master

This block is a bit-serial master that fetches one 16-bit word from a three-wire serial EEPROM. A host pulses `start_i` with a 6-bit word address; the block raises chip select, sends a four-bit command preamble followed by the address, clocks in the 16 data bits and then releases the bus. A one-cycle `done_o` pulse marks the moment `rd_data_o` holds the fetched word.

The serial clock is derived from the system clock. The parameter `PHASE_CYC` sets how many system cycles each serial clock phase lasts, high or low. A read is 26 serial clock pulses plus a closing low phase. The block only reads. While a read is running, further start requests are dropped.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After chip select rises, the first four bits on `mem_dout_o` are 0, 1, 1, 0 in that order: a dummy zero, a start bit of one, then the read opcode one-zero.
- R2: The six address bits follow the preamble, most significant bit first.
- R3: Sixteen data bits are sampled from `mem_din_i` at the end of the clock high phase, most significant bit first. The assembled word is on `rd_data_o` when `done_o` is high.
- R4: `mem_dout_o` changes only while `mem_sclk_o` is low and is stable throughout each high phase.
- R5: Each serial clock high phase and each low phase lasts exactly `PHASE_CYC` system cycles, and one read produces exactly 26 clock pulses.
- R6: Chip select is high from the first preamble bit through the last data bit. One further low-clock phase of `PHASE_CYC` cycles follows with chip select still high, then chip select falls while the clock is low.
- R7: A start request that arrives while `busy_o` is high is ignored. It produces no extra read or done pulse and does not disturb the read in progress.
- R8: `done_o` is high for exactly one cycle per read, and `busy_o` is low in that cycle.
- R9: After reset, chip select, serial clock, data out, busy and done are all low.
- R10: While the 16 data bits are being received, `mem_dout_o` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read request strobe, taken only when idle |
| addr_i | input | 6 | Word address, captured with the strobe |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle pulse, read data valid |
| rd_data_o | output | 16 | Word read from the memory |
| mem_cs_o | output | 1 | Chip select to the memory, active high |
| mem_sclk_o | output | 1 | Serial clock to the memory |
| mem_dout_o | output | 1 | Serial data to the memory |
| mem_din_i | input | 1 | Serial data from the memory |

## Verification
The assertions check on every cycle that the clock never runs without chip select, that data out holds through each high phase, that the done pulse never stretches, that the idle bus is quiet, that chip select falls with the clock low, and that a late start cannot rewind the bit counter. The ordering of preamble and address bits, the assembled data word, the exact phase widths, the pulse count per read and the dropping of a start while busy can only be shown by the bench's memory model and scoreboard over complete reads.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } mw_state_e;

  localparam int unsigned PRE_W = 4;
  localparam logic [PRE_W-1:0] PRE_BITS = 4'b0110;
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int unsigned PHASE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("phase counter out of range"); // R5

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)) else $error("phase counter not cleared"); // R5
endmodule

// File: rtl/mw_shift_unit.sv
module mw_shift_unit
  import mw_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_tx_i,
  input  logic              sample_i,
  input  logic              din_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int unsigned TX_W = PRE_W + ADDR_W;

  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] rx_q;

  // zero fill: once preamble and address are out, the line stays low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tx_q <= '0;
    else if (load_i)     tx_q <= {PRE_BITS, addr_i};
    else if (shift_tx_i) tx_q <= {tx_q[TX_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[DATA_W-2:0], din_i};
  end

  assign tx_bit_o  = tx_q[TX_W-1];
  assign rx_word_o = rx_q;

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && (shift_tx_i || sample_i))) else $error("load during shift"); // R7
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_rd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PHASE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_cs_o,
  output logic              mem_sclk_o,
  output logic              mem_dout_o,
  input  logic              mem_din_i
);
  localparam int unsigned TX_W  = PRE_W + ADDR_W;
  localparam int unsigned TOTAL = TX_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] RX_FIRST = CNT_W'(TX_W);

  mw_state_e        state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic             done_q;
  logic             tick;
  logic             load, shift_tx, sample, tx_bit;
  logic             in_rx;

  assign in_rx    = (bit_cnt_q >= RX_FIRST);
  assign load     = (state_q == ST_IDLE) && start_i;
  assign shift_tx = (state_q == ST_HIGH) && tick && !in_rx;
  assign sample   = (state_q == ST_HIGH) && tick && in_rx;

  mw_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick)
  );

  mw_shift_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .addr_i     (addr_i),
    .shift_tx_i (shift_tx),
    .sample_i   (sample),
    .din_i      (mem_din_i),
    .tx_bit_o   (tx_bit),
    .rx_word_o  (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_LOW;
          bit_cnt_q <= '0;
        end
        ST_LOW: if (tick) state_q <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (bit_cnt_q == LAST_BIT) state_q <= ST_TAIL;
          else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            state_q   <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign mem_cs_o   = (state_q != ST_IDLE);
  assign mem_sclk_o = (state_q == ST_HIGH);
  assign mem_dout_o = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && tx_bit;

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sclk_o |-> mem_cs_o) else $error("clock without select"); // R6

  AST_CS_FALL_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_cs_o) |-> (!mem_sclk_o && !$past(mem_sclk_o))) else $error("select fell with clock high"); // R6

  AST_DOUT_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sclk_o && $past(mem_sclk_o)) |-> $stable(mem_dout_o)) else $error("data moved in high phase"); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done stretched"); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("done while busy"); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_cs_o && !mem_sclk_o && !mem_dout_o)) else $error("idle bus not quiet"); // R9

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tick) |=> $stable(bit_cnt_q)) else $error("start disturbed read"); // R7

  AST_RX_DOUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rx && (state_q == ST_LOW)) |-> !mem_dout_o) else $error("data out during receive"); // R10
endmodule

// File: tb/mw_eeprom_reader_tb_top.sv
module mw_eeprom_reader_tb_top;
  localparam int PHASE = 3;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic busy_o, done_o, mem_cs_o, mem_sclk_o, mem_dout_o;
  logic mem_din_i = 1'b0;
  logic [DW-1:0] rd_data_o;

  int n_checks = 0;
  int n_fails = 0;

  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] addr_q[$];

  always #5 clk_i = ~clk_i;

  mw_eeprom_reader #(.ADDR_W(AW), .DATA_W(DW), .PHASE_CYC(PHASE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o),
    .mem_cs_o(mem_cs_o), .mem_sclk_o(mem_sclk_o), .mem_dout_o(mem_dout_o),
    .mem_din_i(mem_din_i)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a, ~a[3:0], a ^ 6'h2b};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  int rise_n = 0;
  logic [9:0] cmd_cap = '0;
  always @(posedge mem_cs_o) rise_n = 0;
  always @(posedge mem_sclk_o) begin
    logic [DW-1:0] w;
    rise_n++;
    if (rise_n <= 10) cmd_cap = {cmd_cap[8:0], mem_dout_o};
    else if (rise_n <= 26) begin
      w = mem_word(cmd_cap[5:0]);
      mem_din_i = w[26-rise_n];
    end
  end
  always @(negedge mem_cs_o) begin
    logic [AW-1:0] ea;
    check(rise_n == 26, "R5 pulse count", rise_n, 26);
    check(cmd_cap[9:6] == 4'b0110, "R1 preamble", cmd_cap[9:6], 4'b0110);
    ea = (addr_q.size() > 0) ? addr_q.pop_front() : '0;
    check(cmd_cap[5:0] == ea, "R2 address", cmd_cap[5:0], ea);
    check(!mem_sclk_o, "R6 clock low at select fall", mem_sclk_o, 0);
  end

  // cycle monitor and scoreboard
  logic sclk_prev = 0, dout_prev = 0, cs_prev = 0, done_prev = 0;
  int hi_len = 0, lo_len = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_sclk_o && !sclk_prev) begin
        check(lo_len == PHASE, "R5 low phase", lo_len, PHASE);
        lo_len = 0;
      end
      if (!mem_sclk_o && sclk_prev) begin
        check(hi_len == PHASE, "R5 high phase", hi_len, PHASE);
        hi_len = 0;
      end
      if (cs_prev && !mem_cs_o)
        check(lo_len == PHASE, "R6 closing low phase", lo_len, PHASE);
      if (mem_sclk_o && sclk_prev && mem_dout_o != dout_prev)
        check(0, "R4 data moved in high phase", mem_dout_o, dout_prev);
      if (mem_cs_o && !mem_sclk_o && rise_n >= 10)
        check(!mem_dout_o, "R10 data out low in receive", mem_dout_o, 0);
      if (done_prev && done_o) check(0, "R8 done longer than one cycle", 1, 0);
      if (done_o) begin
        logic [DW-1:0] e;
        check(!busy_o, "R8 busy low with done", busy_o, 0);
        if (exp_q.size() == 0) check(0, "R7 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          check(rd_data_o == e, "R3 read word", rd_data_o, e);
        end
      end
      if (mem_sclk_o) hi_len++;
      else if (mem_cs_o) lo_len++;
      else lo_len = 0;
      sclk_prev = mem_sclk_o; dout_prev = mem_dout_o;
      cs_prev = mem_cs_o; done_prev = done_o;
    end
  end

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  task automatic read_word(input logic [AW-1:0] a, input bit poke);
    @(negedge clk_i);
    exp_q.push_back(mem_word(a));
    addr_q.push_back(a);
    start_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk_i);
      start_i = 1'b1; addr_i = ~a;   // R7: must be dropped
      @(negedge clk_i);
      start_i = 1'b0;
      addr_i = '0;
    end
    while (!done_o) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    summary_and_end();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(!mem_cs_o && !mem_sclk_o && !mem_dout_o, "R9 bus low in reset",
          {mem_cs_o, mem_sclk_o, mem_dout_o}, 0);
    check(!busy_o && !done_o, "R9 idle in reset", {busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && !mem_cs_o, "R9 idle after reset", {busy_o, mem_cs_o}, 0);
    read_word(6'h00, 0);
    read_word(6'h3f, 0);
    read_word(6'h2a, 1);
    read_word(6'h15, 0);   // starts in the done cycle's neighbourhood
    read_word(6'h01, 1);
    repeat (4 * PHASE + 10) @(negedge clk_i);
    check(exp_q.size() == 0, "R7 every read completed once", exp_q.size(), 0);
    check(!busy_o && !mem_cs_o, "R7 no extra read from ignored start",
          {busy_o, mem_cs_o}, 0);
    summary_and_end();
  end
endmodule